// File: doc/BRIEF.md
# Transmit Descriptor Chain Validator

The block sits beside a transmit DMA engine and inspects every transmit buffer descriptor before the engine acts on it. Descriptors arrive one per accepted beat on a valid/ready stream. Each beat carries a channel number, start-of-packet, end-of-packet and ownership flags, the next-descriptor pointer, the buffer pointer, the buffer length, and (on start-of-packet beats) the total packet length. The block walks each channel's chain, keeps a running sum of buffer lengths per channel, and checks the descriptor against a fixed set of rules.

On the first violation it records a 4-bit error code and the 3-bit channel, raises a level host-error interrupt and stops taking descriptors. The error is sticky: nothing but reset clears it. A host status read strobe clears only the reported channel field. An idle output shows that the block is out of reset and has no error pending.

Back-pressure rules: a beat is transferred on a rising clock edge where `desc_valid` and `desc_ready` are both high. `desc_ready` is low during reset, for the first clock after reset, and for as long as an error is latched. The producer may hold or change a beat freely while `desc_ready` is low, because nothing is taken.

Top module: `txdesc_validator`

## Requirements
- R1: A descriptor is taken only on an edge where `desc_valid` and `desc_ready` are both high; `desc_ready` is 0 during reset and in the first cycle after it, then 1 until an error is latched, and 0 from then on.
- R2: A descriptor without start-of-packet on a channel that has no open packet gives error code 1.
- R3: A start-of-packet descriptor with the ownership flag clear gives error code 2; the ownership flag of a descriptor that is not start-of-packet is not checked.
- R4: A zero next pointer on a descriptor without end-of-packet gives code 3; a zero buffer pointer gives code 4; a zero buffer length gives code 5. A zero next pointer on an end-of-packet descriptor is legal.
- R5: On an end-of-packet descriptor, if the sum of buffer lengths since that channel's start-of-packet (including this descriptor) is below the packet length captured at start-of-packet, the code is 6. A packet length of zero is never an error. Sums are held per channel, so chains on different channels may interleave.
- R6: When a descriptor breaks several rules, the lowest code is reported (order 1, 2, 3, 4, 5, 6).
- R7: On the edge that takes an erroneous descriptor, `err_code` takes its code, `err_chan` takes its channel and `host_irq` goes high; with no error latched `err_code`, `err_chan` and `host_irq` are 0.
- R8: Once latched, `host_irq` and `err_code` stay unchanged until reset; a `stat_rd` pulse sets `err_chan` to 0 on the next edge and leaves `err_code` alone.
- R9: `idle` is 0 during reset, becomes 1 on the first clock edge after reset is released, and is 0 while an error is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| desc_valid | input | 1 | Descriptor beat valid |
| desc_ready | output | 1 | Block can take a descriptor |
| desc_chan | input | 3 | Channel of the descriptor |
| desc_sop | input | 1 | Start-of-packet flag |
| desc_eop | input | 1 | End-of-packet flag |
| desc_own | input | 1 | Ownership flag (hardware owns buffer) |
| desc_next | input | 32 | Next-descriptor pointer |
| desc_bufptr | input | 32 | Buffer pointer |
| desc_buflen | input | 16 | Buffer length in bytes |
| desc_pktlen | input | 16 | Packet length, used on start-of-packet beats |
| stat_rd | input | 1 | Host status read strobe |
| err_code | output | 4 | Latched error code, 0 = none |
| err_chan | output | 3 | Channel of the latched error |
| host_irq | output | 1 | Host error interrupt, level |
| idle | output | 1 | Out of reset and no error pending |

## Verification
Clean chains are sent as multi-descriptor packets on one channel, as single-descriptor packets (including one with a zero packet length), and as two channels interleaved beat by beat, which separates a per-channel sum from a shared one. Each error code is then provoked alone after a fresh reset, with its channel chosen to differ from the others, so a wrong code or wrong channel shows up. Double faults separate the priority order, a cleared ownership flag on a middle descriptor shows that only start-of-packet beats are checked, and an exact-length versus one-byte-short packet pins the comparison edge. After an error, held traffic and a status read show which fields freeze and which clear.

// File: rtl/txv_pkg.sv
package txv_pkg;
  typedef enum logic [3:0] {
    ERR_NONE     = 4'd0,
    ERR_NO_SOP   = 4'd1,
    ERR_NOT_OWN  = 4'd2,
    ERR_NEXT0    = 4'd3,
    ERR_BUFPTR0  = 4'd4,
    ERR_BUFLEN0  = 4'd5,
    ERR_SHORT    = 4'd6
  } txv_err_e;
endpackage

// File: rtl/txv_rule_check.sv
module txv_rule_check
  import txv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int SUM_W  = 24
) (
  input  logic              sop,
  input  logic              eop,
  input  logic              own,
  input  logic [ADDR_W-1:0] next_ptr,
  input  logic [ADDR_W-1:0] buf_ptr,
  input  logic [LEN_W-1:0]  buf_len,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              chan_open,
  input  logic [SUM_W-1:0]  chan_sum,
  input  logic [LEN_W-1:0]  chan_pkt,
  output txv_err_e          code,
  output logic [SUM_W-1:0]  sum_next
);
  logic [SUM_W-1:0] base;
  logic [SUM_W:0]   wide;
  logic [LEN_W-1:0] target;

  // Running sum including this descriptor, saturating at the top.
  always_comb begin
    base     = sop ? '0 : chan_sum;
    wide     = {1'b0, base} + {{(SUM_W + 1 - LEN_W){1'b0}}, buf_len};
    sum_next = wide[SUM_W] ? {SUM_W{1'b1}} : wide[SUM_W-1:0];
    target   = sop ? pkt_len : chan_pkt;
  end

  // Priority: lowest code wins.
  always_comb begin
    code = ERR_NONE;
    if (!sop && !chan_open)
      code = ERR_NO_SOP;
    else if (sop && !own)
      code = ERR_NOT_OWN;
    else if (next_ptr == '0 && !eop)
      code = ERR_NEXT0;
    else if (buf_ptr == '0)
      code = ERR_BUFPTR0;
    else if (buf_len == '0)
      code = ERR_BUFLEN0;
    else if (eop && (sum_next < {{(SUM_W - LEN_W){1'b0}}, target}))
      code = ERR_SHORT;
  end
endmodule

// File: rtl/txv_chan_track.sv
module txv_chan_track #(
  parameter int CHANS = 8,
  parameter int LEN_W = 16,
  parameter int SUM_W = 24,
  localparam int CH_W = $clog2(CHANS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [CH_W-1:0]  chan,
  input  logic             sop,
  input  logic             eop,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [SUM_W-1:0] sum_next,
  output logic             cur_open,
  output logic [SUM_W-1:0] cur_sum,
  output logic [LEN_W-1:0] cur_pkt
);
  logic [CHANS-1:0] open_q;
  logic [SUM_W-1:0] sum_q [CHANS];
  logic [LEN_W-1:0] pkt_q [CHANS];

  for (genvar c = 0; c < CHANS; c++) begin : g_ch
    logic hit;
    assign hit = upd && (chan == CH_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[c] <= 1'b0;
        sum_q[c]  <= '0;
        pkt_q[c]  <= '0;
      end else if (hit) begin
        open_q[c] <= !eop;
        sum_q[c]  <= sum_next;
        if (sop) pkt_q[c] <= pkt_len;
      end
    end

    AST_OPEN_ON_SOP: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sop && !eop) |=> open_q[c]); // R5
    AST_CLOSE_ON_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && eop) |=> !open_q[c]); // R5
  end

  assign cur_open = open_q[chan];
  assign cur_sum  = sum_q[chan];
  assign cur_pkt  = pkt_q[chan];
endmodule

// File: rtl/txv_err_latch.sv
module txv_err_latch
  import txv_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  txv_err_e        code,
  input  logic [CH_W-1:0] chan,
  input  logic            stat_rd,
  output logic [3:0]      err_code,
  output logic [CH_W-1:0] err_chan,
  output logic            host_irq,
  output logic            accept_en
);
  logic            live_q;
  logic            irq_q;
  logic [3:0]      code_q;
  logic [CH_W-1:0] chan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      irq_q  <= 1'b0;
      code_q <= '0;
      chan_q <= '0;
    end else begin
      live_q <= 1'b1;
      if (!irq_q && take && code != ERR_NONE) begin
        irq_q  <= 1'b1;
        code_q <= code;
        chan_q <= chan;
      end else if (stat_rd) begin
        chan_q <= '0;
      end
    end
  end

  assign accept_en = live_q && !irq_q;
  assign err_code  = code_q;
  assign err_chan  = chan_q;
  assign host_irq  = irq_q;

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> irq_q); // R8
  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> $stable(code_q)); // R8
  AST_READ_CLEARS_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && stat_rd) |=> chan_q == '0); // R8
  AST_QUIET_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q |-> (code_q == '0 && chan_q == '0)); // R7
endmodule

// File: rtl/txdesc_validator.sv
module txdesc_validator
  import txv_pkg::*;
#(
  parameter int CHANS  = 8,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int SUM_EXTRA = 8,
  localparam int CH_W  = $clog2(CHANS),
  localparam int SUM_W = LEN_W + SUM_EXTRA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [CH_W-1:0]   desc_chan,
  input  logic              desc_sop,
  input  logic              desc_eop,
  input  logic              desc_own,
  input  logic [ADDR_W-1:0] desc_next,
  input  logic [ADDR_W-1:0] desc_bufptr,
  input  logic [LEN_W-1:0]  desc_buflen,
  input  logic [LEN_W-1:0]  desc_pktlen,
  input  logic              stat_rd,
  output logic [3:0]        err_code,
  output logic [CH_W-1:0]   err_chan,
  output logic              host_irq,
  output logic              idle
);
  logic             take;
  logic             accept_en;
  logic             cur_open;
  logic [SUM_W-1:0] cur_sum;
  logic [LEN_W-1:0] cur_pkt;
  logic [SUM_W-1:0] sum_next;
  txv_err_e         rule_code;

  assign desc_ready = accept_en;
  assign idle       = accept_en;
  assign take       = desc_valid && accept_en;

  txv_rule_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SUM_W(SUM_W)) u_rules (
    .sop(desc_sop), .eop(desc_eop), .own(desc_own),
    .next_ptr(desc_next), .buf_ptr(desc_bufptr),
    .buf_len(desc_buflen), .pkt_len(desc_pktlen),
    .chan_open(cur_open), .chan_sum(cur_sum), .chan_pkt(cur_pkt),
    .code(rule_code), .sum_next(sum_next)
  );

  txv_chan_track #(.CHANS(CHANS), .LEN_W(LEN_W), .SUM_W(SUM_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .upd(take && rule_code == ERR_NONE),
    .chan(desc_chan), .sop(desc_sop), .eop(desc_eop),
    .pkt_len(desc_pktlen), .sum_next(sum_next),
    .cur_open(cur_open), .cur_sum(cur_sum), .cur_pkt(cur_pkt)
  );

  txv_err_latch #(.CH_W(CH_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .take(take), .code(rule_code),
    .chan(desc_chan), .stat_rd(stat_rd),
    .err_code(err_code), .err_chan(err_chan),
    .host_irq(host_irq), .accept_en(accept_en)
  );

  AST_LATCH_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rule_code != ERR_NONE) |=>
      (host_irq && err_code == 4'($past(rule_code)) && err_chan == $past(desc_chan))); // R7
  AST_OWN_AT_SOP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && desc_sop && !desc_own) |-> rule_code == ERR_NOT_OWN); // R3
  AST_NO_TAKE_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> ($stable(err_code) && !idle)); // R9
endmodule

// File: tb/sim_txdesc_validator.sv
module sim_txdesc_validator;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0] code;
    logic [2:0] ch;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [2:0]  desc_chan = '0;
  logic        desc_sop = 1'b0, desc_eop = 1'b0, desc_own = 1'b0;
  logic [31:0] desc_next = '0, desc_bufptr = '0;
  logic [15:0] desc_buflen = '0, desc_pktlen = '0;
  logic        stat_rd = 1'b0;
  logic [3:0]  err_code;
  logic [2:0]  err_chan;
  logic        host_irq, idle;

  int checks = 0;
  int failures = 0;
  exp_t q[$];
  logic acc_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txdesc_validator u0 (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_chan(desc_chan), .desc_sop(desc_sop), .desc_eop(desc_eop),
    .desc_own(desc_own), .desc_next(desc_next), .desc_bufptr(desc_bufptr),
    .desc_buflen(desc_buflen), .desc_pktlen(desc_pktlen), .stat_rd(stat_rd),
    .err_code(err_code), .err_chan(err_chan), .host_irq(host_irq), .idle(idle)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: one comparison per accepted beat, half a cycle after the edge.
  always @(posedge clk) acc_seen <= desc_valid && desc_ready;

  always @(negedge clk) begin
    if (acc_seen) begin
      if (q.size() == 0) begin
        check(1'b0, "R1 unexpected accept", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(err_code == e.code, {e.tag, " code"}, err_code, e.code);
        check(err_chan == e.ch,   {e.tag, " chan"}, err_chan, e.ch);
        check(host_irq == (e.code != 0), {e.tag, " irq"}, host_irq, e.code != 0);
      end
    end
  end

  task automatic send(input logic [2:0] ch, input bit sop, input bit eop, input bit own,
                      input logic [31:0] nxt, input logic [31:0] bp,
                      input logic [15:0] bl, input logic [15:0] pl,
                      input logic [3:0] ecode, input string tag);
    exp_t e;
    e.code = ecode;
    e.ch   = (ecode != 0) ? ch : 3'd0;
    e.tag  = tag;
    q.push_back(e);
    @(negedge clk);
    desc_chan = ch; desc_sop = sop; desc_eop = eop; desc_own = own;
    desc_next = nxt; desc_bufptr = bp; desc_buflen = bl; desc_pktlen = pl;
    desc_valid = 1'b1;
    @(posedge clk);
    #1 desc_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1 watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Reset state
    repeat (2) @(negedge clk);
    check(idle == 0, "R9 idle in reset", idle, 0);
    check(desc_ready == 0, "R1 ready in reset", desc_ready, 0);
    check(host_irq == 0 && err_code == 0, "R7 no error in reset", err_code, 0);
    rst_n = 1'b1;
    #1 check(idle == 0, "R9 idle before first edge", idle, 0);
    @(negedge clk);
    check(idle == 1, "R9 idle one clock after reset", idle, 1);
    check(desc_ready == 1, "R1 ready after reset", desc_ready, 1);

    // Clean chain on one channel, middle descriptor not owned (R3), EOP with zero next (R4)
    send(3'd2, 1, 0, 1, 32'h100, 32'h1000, 16'd100, 16'd300, 0, "R5 chain sop");
    send(3'd2, 0, 0, 0, 32'h200, 32'h2000, 16'd100, 16'd0,   0, "R3 middle unowned");
    send(3'd2, 0, 1, 1, 32'h0,   32'h3000, 16'd100, 16'd0,   0, "R4 eop zero next ok");
    // Interleaved channels (R5)
    send(3'd1, 1, 0, 1, 32'h10, 32'h1, 16'd50, 16'd80, 0, "R5 ilv c1 sop");
    send(3'd3, 1, 0, 1, 32'h10, 32'h1, 16'd10, 16'd20, 0, "R5 ilv c3 sop");
    send(3'd1, 0, 1, 1, 32'h0,  32'h1, 16'd30, 16'd0,  0, "R5 ilv c1 eop exact");
    send(3'd3, 0, 1, 1, 32'h0,  32'h1, 16'd10, 16'd0,  0, "R5 ilv c3 eop exact");
    // Zero packet length single descriptor (R5)
    send(3'd0, 1, 1, 1, 32'h0, 32'h1, 16'd4, 16'd0, 0, "R5 zero pktlen");
    repeat (2) @(negedge clk);
    check(host_irq == 0 && idle == 1, "R9 idle with no error", idle, 1);

    // Code 1
    do_reset();
    send(3'd5, 0, 1, 1, 32'h0, 32'h1, 16'd4, 16'd0, 4'd1, "R2 missing sop");
    // Code 2, then stickiness and read strobe (R1, R8, R9)
    do_reset();
    send(3'd6, 1, 1, 0, 32'h0, 32'h1, 16'd4, 16'd4, 4'd2, "R3 sop not owned");
    @(negedge clk);
    check(desc_ready == 0, "R1 ready low in error", desc_ready, 0);
    check(idle == 0, "R9 idle low in error", idle, 0);
    desc_chan = 3'd1; desc_sop = 0; desc_eop = 1; desc_own = 1;
    desc_bufptr = 0; desc_valid = 1'b1;
    repeat (3) @(negedge clk);
    desc_valid = 1'b0;
    check(err_code == 2, "R8 code held under traffic", err_code, 2);
    check(err_chan == 6, "R8 chan held under traffic", err_chan, 6);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check(err_chan == 0, "R8 read clears chan", err_chan, 0);
    check(err_code == 2, "R8 read keeps code", err_code, 2);
    check(host_irq == 1, "R8 irq held after read", host_irq, 1);
    repeat (5) @(negedge clk);
    check(host_irq == 1 && err_code == 2, "R8 sticky until reset", err_code, 2);

    // Code 3, 4, 5
    do_reset();
    send(3'd7, 1, 0, 1, 32'h0, 32'h1, 16'd4, 16'd4, 4'd3, "R4 zero next no eop");
    do_reset();
    send(3'd3, 1, 1, 1, 32'h0, 32'h0, 16'd4, 16'd4, 4'd4, "R4 zero bufptr");
    do_reset();
    send(3'd1, 1, 1, 1, 32'h0, 32'h8, 16'd0, 16'd4, 4'd5, "R4 zero buflen");
    // Code 6: one byte short across a chain
    do_reset();
    send(3'd4, 1, 0, 1, 32'h4, 32'h8, 16'd60, 16'd121, 0, "R5 short sop");
    send(3'd4, 0, 1, 1, 32'h0, 32'h8, 16'd60, 16'd0,   4'd6, "R5 short eop");
    // Priority (R6)
    do_reset();
    send(3'd2, 1, 1, 0, 32'h0, 32'h0, 16'd0, 16'd9, 4'd2, "R6 own beats bufptr");
    do_reset();
    send(3'd3, 0, 0, 0, 32'h0, 32'h0, 16'd0, 16'd0, 4'd1, "R6 sop beats all");
    do_reset();
    send(3'd5, 1, 0, 1, 32'h0, 32'h0, 16'd0, 16'd0, 4'd3, "R6 next beats bufptr");
    do_reset();
    send(3'd6, 1, 1, 1, 32'h0, 32'h8, 16'd0, 16'd50, 4'd5, "R6 len0 beats short");
    @(negedge clk);
    @(negedge clk);
    check(q.size() == 0, "R1 all beats taken", q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule